// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is a local interrupt timer. Software loads a starting value into the start-count register. The count then runs down by one on every prescaler tick. The prescaler divides the input clock by a power of two, and the power comes from a 3-bit code that is spread over non-adjacent bits of the divide register. A control entry holds an interrupt vector, a mask bit and a repeat bit. When the count steps from one to zero, the block raises a one-cycle delivery request that carries the vector, unless the mask bit is set.

In repeat mode the count goes back to the start value on the tick after it reaches zero, so a request recurs every start+1 ticks. In single mode the count stays at zero. Writing a new start value restarts both the count and the prescaler. All registers can be read through a simple select port, and the running count also has its own output.

Top module: `divtimer`

## Requirements
- R1: After reset, the start count, the running count, the divide register and the control entry all read 0, and `irq_valid` is low. The divide register at 0 gives a shift of 1, which is a divide by 2.
- R2: A write to the divide register (wr_sel 2) stores only bits 3, 1 and 0 of the data. Writing 0xFF reads back as 0xB.
- R3: The divide code is {bit3, bit1, bit0} of the divide register, and the shift is (code+1) mod 8. The running count steps once every 2^shift clocks, and its first step comes 2^shift clocks after the start-count write takes effect.
- R4: In repeat mode (control bit 17 set), the count runs start, start-1, …, 0. On the next tick it returns to start.
- R5: In single mode (control bit 17 clear), the count stops at 0 and stays there.
- R6: A start-count write (wr_sel 0) loads the count and clears the prescaler on the following clock edge. If a tick falls in the same cycle as the write, the write wins and that tick causes no step and no request.
- R7: A request is raised when a tick moves the count from 1 to 0. `irq_valid` is high for one cycle, in the same cycle that the count first reads 0, and `irq_vector` then equals control bits 7:0. No request is raised while the mask bit (control bit 16) is set.
- R8: A start count of 0 keeps the running count at 0 and never raises a request.
- R9: A control-entry write (wr_sel 3) takes effect at the next tick. If a finished single-mode count is switched to repeat mode, it reloads the start value on the following tick.
- R10: The read select chooses the value on rd_data: 0 gives the start count, 1 the running count, 2 the divide register, and 3 the control entry. The control entry keeps only bits 17:16 and 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 start count, 2 divide, 3 control entry; 1 is not writable |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read target (see R10) |
| rd_data | output | DATA_W | Selected register value |
| cur_count | output | CNT_W | Running count |
| irq_valid | output | 1 | One-cycle delivery request |
| irq_vector | output | VEC_W | Vector carried by the request |

## Verification
Two events can land in the same cycle: a start-count write and a prescaler tick that would move the count from 1 to 0. The bench sets the divide to 1, loads a start value of 2, and issues a second start-count write two edges later, exactly when the expiry is due. It then checks that no request appears and that the count shows the new value. A cycle-by-cycle behavioural model, compared on every clock, judges this case and every other stretch of the run. The same model also covers a control-entry write that arrives while a single-mode count sits at zero.

// File: rtl/divtimer_pkg.sv
// Shared definitions for the divided countdown timer.
package divtimer_pkg;
    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_DIV   = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    localparam int MASK_POS   = 16;
    localparam int REPEAT_POS = 17;
    localparam int SHIFT_W    = 3;

    // Gather the spread divide code and turn it into a shift amount.
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [3:0] d);
        logic [SHIFT_W-1:0] code;
        code = {d[3], d[1], d[0]};
        return code + 3'd1;
    endfunction
endpackage

// File: rtl/divtimer_prescale.sv
// Power-of-two clock prescaler.
// Emits a tick every 2^shift clocks. The restart input clears the phase.
// Assumes the shift may change at any time; a larger current phase ticks at once.
module divtimer_prescale #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int PRE_W = (1 << SHIFT_W) - 1;

    logic [PRE_W-1:0] phase;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] limit;

    // Terminal phase value for the selected divide.
    always_comb begin
        span  = {{PRE_W{1'b0}}, 1'b1} << shift;
        limit = span[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
    end

    assign tick = (phase >= limit);

    // Advance the phase, wrapping on tick and clearing on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) phase <= '0;
        else                           phase <= phase + 1'b1;
    end

    // R3
    tick_clears_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase == '0));
endmodule

// File: rtl/divtimer_count.sv
// Down counter with repeat and single modes.
// Steps on tick. Reports expire_now when a tick would move it from 1 to 0.
// A load takes priority over a tick in the same cycle.
module divtimer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] start_val,
    input  logic             tick,
    input  logic             repeat_mode,
    output logic [CNT_W-1:0] count,
    output logic             expire_now
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire_now = tick && !load && (count == ONE);

    // Load, step down, reload in repeat mode, or hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (load)                 count <= load_val;
        else if (tick) begin
            if (count != '0)           count <= count - ONE;
            else if (repeat_mode)      count <= start_val;
        end
    end

    // R5
    single_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !repeat_mode && count == '0) |=> (count == '0));

    // R4
    repeat_reloads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && repeat_mode && count == '0) |=> (count == $past(start_val)));

    // R6
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/divtimer.sv
// Divided countdown interrupt timer, top level.
// Holds the start, divide and control registers, connects the prescaler and
// the counter, and registers the one-cycle delivery request.
// Assumes DATA_W >= 18 and CNT_W <= DATA_W.
module divtimer
    import divtimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cur_count,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    logic [CNT_W-1:0]   start_q;
    logic [3:0]         div_q;
    logic [VEC_W-1:0]   vec_q;
    logic               mask_q;
    logic               repeat_q;
    logic               ld_start;
    logic               tick;
    logic               expire_now;
    logic [SHIFT_W-1:0] shift;

    assign ld_start = wr_en && (wr_sel == SEL_START);
    assign shift    = div_to_shift(div_q);

    // Register writes from the simple write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q  <= '0;
            div_q    <= '0;
            vec_q    <= '0;
            mask_q   <= 1'b0;
            repeat_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_START: start_q <= wr_data[CNT_W-1:0];
                SEL_DIV:   div_q   <= {wr_data[3], 1'b0, wr_data[1:0]};
                SEL_CTRL: begin
                    vec_q    <= wr_data[VEC_W-1:0];
                    mask_q   <= wr_data[MASK_POS];
                    repeat_q <= wr_data[REPEAT_POS];
                end
                default: ;
            endcase
        end
    end

    divtimer_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ld_start),
        .shift   (shift),
        .tick    (tick)
    );

    divtimer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (ld_start),
        .load_val    (wr_data[CNT_W-1:0]),
        .start_val   (start_q),
        .tick        (tick),
        .repeat_mode (repeat_q),
        .count       (cur_count),
        .expire_now  (expire_now)
    );

    // Register the delivery request and capture its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= expire_now && !mask_q;
            if (expire_now) irq_vector <= vec_q;
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_START: rd_data = DATA_W'(start_q);
            SEL_COUNT: rd_data = DATA_W'(cur_count);
            SEL_DIV:   rd_data = DATA_W'(div_q);
            default: begin
                rd_data[VEC_W-1:0]  = vec_q;
                rd_data[MASK_POS]   = mask_q;
                rd_data[REPEAT_POS] = repeat_q;
            end
        endcase
    end

    // R7
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (cur_count == '0));

    // R7
    irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid || (start_q == '0 && 1'b0) || cur_count == '0 && $past(start_q) == '0);

    // R8
    zero_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q == '0 && !ld_start && cur_count == '0) |=> !irq_valid);
endmodule

// File: tb/divtimer_tb.sv
`timescale 1ns/1ps
module divtimer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [31:0] cur_count;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;

    // behavioural reference state
    logic [31:0] m_count, m_start;
    int          m_pre, m_shift;
    logic [3:0]  m_div;
    logic [7:0]  m_vec, m_irqvec;
    logic        m_mask, m_rep, m_irq;

    always #5 clk = ~clk;

    divtimer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .cur_count(cur_count), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    function automatic int shift_of(input logic [3:0] d);
        int code;
        code = (d[1:0]) + (d[3] ? 4 : 0);
        return (code + 1) % 8;
    endfunction

    // Reference model, advanced on each rising edge from pre-edge values.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_start = 0; m_pre = 0; m_div = 0; m_shift = 1;
            m_vec = 0; m_mask = 0; m_rep = 0; m_irq = 0; m_irqvec = 0;
        end else begin
            bit tk;
            bit fire;
            tk = (m_pre >= (1 << m_shift) - 1);
            fire = 0;
            if (wr_en && wr_sel == 2'd0) begin
                m_count = wr_data;
                m_pre = 0;
            end else begin
                m_pre = tk ? 0 : m_pre + 1;
                if (tk) begin
                    if (m_count == 1) begin m_count = 0; fire = 1; end
                    else if (m_count != 0) m_count = m_count - 1;
                    else if (m_rep) m_count = m_start;
                end
            end
            m_irq = fire && !m_mask;
            if (fire) m_irqvec = m_vec;
            if (wr_en) begin
                case (wr_sel)
                    2'd0: m_start = wr_data;
                    2'd2: begin m_div = {wr_data[3], 1'b0, wr_data[1:0]}; m_shift = shift_of(m_div); end
                    2'd3: begin m_vec = wr_data[7:0]; m_mask = wr_data[16]; m_rep = wr_data[17]; end
                    default: ;
                endcase
            end
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (cur_count !== m_count) begin
                errors++;
                $display("FAIL %s count: actual %0d expected %0d", m_rep ? "R4" : "R5", cur_count, m_count);
            end
            checks++;
            if (irq_valid !== m_irq || (m_irq && irq_vector !== m_irqvec)) begin
                errors++;
                $display("FAIL R7 irq: actual %0b/%h expected %0b/%h", irq_valid, irq_vector, m_irq, m_irqvec);
            end
            if (irq_valid) irq_seen++;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [1:0] sel, input logic [31:0] exp);
        @(negedge clk); #1;
        rd_sel = sel; #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state, R10 read select
        chk_rd("R1 start", 2'd0, 32'd0);
        chk_rd("R1 count", 2'd1, 32'd0);
        chk_rd("R1 div", 2'd2, 32'd0);
        chk_rd("R10 ctrl", 2'd3, 32'd0);
        chk("R1 irq", {31'd0, irq_valid}, 32'd0);
        // R2 divide mask
        wr(2'd2, 32'hFF);
        chk_rd("R2 div", 2'd2, 32'hB);
        // R10 control entry keeps 17:16 and 7:0
        wr(2'd3, 32'hFFFF_FF41);
        chk_rd("R10 ctrl", 2'd3, 32'h0003_0041);
        // R5 single mode, divide by 1
        wr(2'd3, 32'h0000_0041);
        irq_seen = 0;
        wr(2'd0, 32'd5);
        chk_rd("R10 start", 2'd0, 32'd5);
        idle(12);
        chk("R5 irq once", irq_seen, 32'd1);
        chk("R5 hold", cur_count, 32'd0);
        // R4 repeat mode, R3 divide by 2
        wr(2'd2, 32'h0);
        wr(2'd3, 32'h0002_0052);
        irq_seen = 0;
        wr(2'd0, 32'd3);
        idle(39);
        chk("R4 repeats", irq_seen, 32'd5);
        // R3 divide by 32 (code 4)
        wr(2'd2, 32'h8);
        wr(2'd0, 32'd2);
        idle(200);
        // R7 masked
        wr(2'd3, 32'h0003_0063);
        irq_seen = 0;
        idle(150);
        chk("R7 mask", irq_seen, 32'd0);
        // R8 zero start
        wr(2'd2, 32'hB);
        wr(2'd3, 32'h0002_0070);
        wr(2'd0, 32'd0);
        irq_seen = 0;
        idle(20);
        chk("R8 idle", irq_seen, 32'd0);
        chk("R8 count", cur_count, 32'd0);
        // R6 collision: reload on the expiry edge
        irq_seen = 0;
        wr(2'd0, 32'd2);
        wr(2'd0, 32'd7);
        chk("R6 no irq", irq_seen, 32'd0);
        idle(3);
        // R9 finished single count switched to repeat
        wr(2'd3, 32'h0000_0011);
        wr(2'd0, 32'd2);
        idle(6);
        chk("R9 held", cur_count, 32'd0);
        wr(2'd3, 32'h0002_0011);
        idle(1);
        chk("R9 reload", cur_count != 0, 32'd1);
        idle(10);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule